// File: doc/BRIEF.md
# Codec Serial Frame Controller

This block runs the digital side of a frame-based synchronous serial link to a converter. A host exchanges 16-bit words with it. Each frame begins with a frame-sync pulse sampled on a shift tick. After that, one bit moves in each direction on every following shift tick, most significant bit first.

A normal frame carries a primary word. Its two low bits are a command: nothing, phase advance, phase retard or secondary request. A secondary frame follows any primary frame that requested one. A secondary word can write a 3-bit mode register, which selects three behaviours:
- 16-bit compatibility, where the command bits are treated as data;
- forced secondary frames;
- free-run operation, where the external frame sync only moves data and internal timing comes from a separate sample-timing generator.

The outgoing data comes from a conversion-data latch, which an internal load strobe fills. In free-run mode, a rule settles which of the external frame sync and the internal load goes first when they collide. A sticky flag records any external frame sync that falls too far from the internal frame sync.

Top module: `sfc_frame_ctrl`

## Requirements
- R1: After synchronous reset, `dout`, `phase_adv`, `phase_ret`, `sec_req`, `rx_valid` and `err_window` are 0, and the mode register is 0.
- R2: A frame starts on a shift tick with `fsync` high while no frame is active. The next 16 shift ticks each shift one bit in on `din` and one bit out on `dout`, MSB first. At frame start `dout` shows bit 15, and after the k-th shift tick it shows bit 15-k. A completed primary word appears on `rx_data` with a one-cycle `rx_valid`.
- R3: With 16-bit mode off, the primary word's bits [1:0] decode as follows, each giving one single-cycle pulse per word: 00 gives nothing, 01 gives `phase_advance`, 10 gives `phase_ret`, and 11 gives `sec_req`.
- R4: The frame after a primary word that raised `sec_req` is a secondary frame. Its word is not decoded as a command, and it shifts out zeros. If its bits [15:8] equal the mode address (6), its bits [2:0] load the mode register: bit 0 selects 16-bit mode, bit 1 selects free-run and bit 2 selects force-secondary. A secondary word with any other address leaves the mode unchanged.
- R5: In 16-bit mode, bits [1:0] cause no phase request, and every primary word raises `sec_req`. The mode persists until a secondary write clears bit 0.
- R6: With force-secondary set, every primary word raises `sec_req` whatever its command bits, and the advance and retard commands still produce their pulses.
- R7: `pin_adv` and `pin_ret`, sampled when a primary word completes, also produce the matching phase pulse. The timing of the external frame sync never produces a phase pulse.
- R8: Outside free-run, `int_load` copies `conv_data` into the output latch. If it coincides with a frame start, that frame shifts out the new data.
- R9: In free-run, an `int_load` that coincides with a frame start, or arrives during a frame, does not change the current frame, which shifts out the old latch contents. The new `conv_data` is latched once all 16 bits are out and is sent in the next frame.
- R10: In free-run, a frame start that comes more than HALF_WIN and fewer than FRAME_CLKS-HALF_WIN clock cycles after the last `int_fs` sets `err_window`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_tick | input | 1 | One-cycle pulse per serial bit period |
| fsync | input | 1 | External frame sync, sampled on shift ticks |
| din | input | 1 | Serial data from host |
| int_load | input | 1 | Internal conversion-data load strobe |
| int_fs | input | 1 | Internal frame-sync pulse from timing generator |
| conv_data | input | W | Conversion result to send |
| pin_adv | input | 1 | Hardware phase-advance request |
| pin_ret | input | 1 | Hardware phase-retard request |
| dout | output | 1 | Serial data to host |
| phase_adv | output | 1 | Phase-advance request pulse |
| phase_ret | output | 1 | Phase-retard request pulse |
| sec_req | output | 1 | Secondary-frame request pulse |
| rx_data | output | W | Last received primary word |
| rx_valid | output | 1 | Pulse when rx_data updates |
| err_window | output | 1 | Sticky free-run frame-sync window error |

## Verification
If the bit counter or the frame-type flag goes wrong, it shows up within one frame. `dout` shows a shifted or zeroed word, or a command pulse is missing or extra, two cycles after the last shift tick. A mode register holding the wrong value is caught on the next primary frame, through the `sec_req` and phase pulses it produces. A latch that updates at the wrong moment shows up as the wrong word in the current frame or the next one. The window error flag is read straight after each free-run frame start.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int MODE_BITS   = 3;
  localparam int MODE_SIXTEEN = 0;
  localparam int MODE_FREE    = 1;
  localparam int MODE_FORCE   = 2;

  typedef logic [MODE_BITS-1:0] mode_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_ADV  = 2'b01,
    CMD_RET  = 2'b10,
    CMD_SEC  = 2'b11
  } cmd_e;
endpackage

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] load_val,
  input  logic         din,
  output logic         busy,
  output logic         dout,
  output logic         word_done,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  out_sr;
  logic [W-2:0]  in_sr;

  assign busy = (cnt != '0);
  assign dout = out_sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      out_sr    <= '0;
      in_sr     <= '0;
      word_done <= 1'b0;
      word      <= '0;
    end else begin
      word_done <= 1'b0;
      if (tick && busy) begin
        out_sr <= {out_sr[W-2:0], 1'b0};
        in_sr  <= {in_sr[W-3:0], din};
        cnt    <= cnt - CNT_ONE;
        if (cnt == CNT_ONE) begin
          word_done <= 1'b1;
          word      <= {in_sr, din};
        end
      end else if (start) begin
        cnt    <= CNT_FULL;
        out_sr <= load_val;
      end
    end
  end

  // R2: a word completes only once the bit count has run out
  assert_done_at_count_end_R2: assert property (@(posedge clk) disable iff (rst)
    word_done |-> (cnt == '0));
endmodule

// File: rtl/sfc_decode.sv
module sfc_decode
  import sfc_pkg::*;
#(
  parameter int          W         = 16,
  parameter logic [7:0]  MODE_ADDR = 8'h06
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         word_done,
  input  logic [W-1:0] word,
  input  logic         pin_adv,
  input  logic         pin_ret,
  output logic         phase_adv,
  output logic         phase_ret,
  output logic         sec_req,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic         sec_pend,
  output mode_t        mode
);
  cmd_e cmd;
  logic sixteen, force_sec, want_sec;

  assign cmd       = cmd_e'(word[1:0]);
  assign sixteen   = mode[MODE_SIXTEEN];
  assign force_sec = mode[MODE_FORCE];
  assign want_sec  = force_sec | sixteen | (cmd == CMD_SEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_adv <= 1'b0;
      phase_ret <= 1'b0;
      sec_req   <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      sec_pend  <= 1'b0;
      mode      <= '0;
    end else begin
      phase_adv <= 1'b0;
      phase_ret <= 1'b0;
      sec_req   <= 1'b0;
      rx_valid  <= 1'b0;
      if (word_done) begin
        if (sec_pend) begin
          sec_pend <= 1'b0;
          if (word[W-1 -: 8] == MODE_ADDR) mode <= word[MODE_BITS-1:0];
        end else begin
          rx_data   <= word;
          rx_valid  <= 1'b1;
          phase_adv <= (!sixteen && cmd == CMD_ADV) || pin_adv;
          phase_ret <= (!sixteen && cmd == CMD_RET) || pin_ret;
          sec_req   <= want_sec;
          sec_pend  <= want_sec;
        end
      end
    end
  end

  // R6: forced secondary is honoured on every primary word
  assert_force_secondary_R6: assert property (@(posedge clk) disable iff (rst)
    (word_done && !sec_pend && mode[MODE_FORCE]) |=> sec_req);
  // R5: 16-bit mode asks for a secondary frame every primary word
  assert_sixteen_secondary_R5: assert property (@(posedge clk) disable iff (rst)
    (word_done && !sec_pend && mode[MODE_SIXTEEN]) |=> (sec_req && sec_pend));
endmodule

// File: rtl/sfc_window.sv
module sfc_window #(
  parameter int FRAME_CLKS = 80,
  parameter int HALF_WIN   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic int_fs,
  input  logic ext_start,
  output logic err
);
  localparam int SW = $clog2(FRAME_CLKS + 1);
  localparam logic [SW-1:0] SAT = SW'(FRAME_CLKS);
  localparam logic [SW-1:0] LO  = SW'(HALF_WIN);
  localparam logic [SW-1:0] HI  = SW'(FRAME_CLKS - HALF_WIN);

  logic [SW-1:0] since;
  logic          outside;

  assign outside = (since > LO) && (since < HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      err   <= 1'b0;
    end else begin
      if (int_fs)          since <= '0;
      else if (since != SAT) since <= since + SW'(1);
      if (ext_start && outside) err <= 1'b1;
    end
  end

  // R10: the window error is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/sfc_frame_ctrl.sv
module sfc_frame_ctrl
  import sfc_pkg::*;
#(
  parameter int         W          = 16,
  parameter int         FRAME_CLKS = 80,
  parameter int         HALF_WIN   = 8,
  parameter logic [7:0] MODE_ADDR  = 8'h06
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_tick,
  input  logic         fsync,
  input  logic         din,
  input  logic         int_load,
  input  logic         int_fs,
  input  logic [W-1:0] conv_data,
  input  logic         pin_adv,
  input  logic         pin_ret,
  output logic         dout,
  output logic         phase_adv,
  output logic         phase_ret,
  output logic         sec_req,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic         err_window
);
  logic         busy, start, word_done, sec_pend, free, load_pend;
  logic [W-1:0] word, hold_reg, load_val;
  mode_t        mode;

  assign start    = shift_tick && fsync && !busy;
  assign free     = mode[MODE_FREE];
  assign load_val = sec_pend ? '0 : ((int_load && !free) ? conv_data : hold_reg);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_reg  <= '0;
      load_pend <= 1'b0;
    end else if (int_load && free && (start || busy)) begin
      load_pend <= 1'b1;
    end else if (int_load) begin
      hold_reg  <= conv_data;
      load_pend <= 1'b0;
    end else if (load_pend && !busy && !start) begin
      hold_reg  <= conv_data;
      load_pend <= 1'b0;
    end
  end

  sfc_shifter #(.W(W)) i_shift (
    .clk(clk), .rst(rst), .tick(shift_tick), .start(start),
    .load_val(load_val), .din(din), .busy(busy), .dout(dout),
    .word_done(word_done), .word(word)
  );

  sfc_decode #(.W(W), .MODE_ADDR(MODE_ADDR)) i_dec (
    .clk(clk), .rst(rst), .word_done(word_done), .word(word),
    .pin_adv(pin_adv), .pin_ret(pin_ret), .phase_adv(phase_adv),
    .phase_ret(phase_ret), .sec_req(sec_req), .rx_data(rx_data),
    .rx_valid(rx_valid), .sec_pend(sec_pend), .mode(mode)
  );

  sfc_window #(.FRAME_CLKS(FRAME_CLKS), .HALF_WIN(HALF_WIN)) i_win (
    .clk(clk), .rst(rst), .int_fs(int_fs), .ext_start(start && free),
    .err(err_window)
  );

  // R9: in free-run the output latch is frozen while bits are shifting
  assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (free && $past(free) && busy && $past(busy)) |-> $stable(hold_reg));
endmodule

// File: tb/test_sfc_frame_ctrl.sv
module test_sfc_frame_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_tick = 1'b0, fsync = 1'b0, din = 1'b0, int_load = 1'b0, int_fs = 1'b0;
  logic pin_adv = 1'b0, pin_ret = 1'b0;
  logic [15:0] conv_data = 16'h0;
  logic dout, phase_adv, phase_ret, sec_req, rx_valid, err_window;
  logic [15:0] rx_data;

  int checks = 0, fails = 0;
  int n_adv = 0, n_ret = 0, n_sec = 0, n_val = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sfc_frame_ctrl i_sfc_frame_ctrl (
    .clk(clk), .rst(rst), .shift_tick(shift_tick), .fsync(fsync), .din(din),
    .int_load(int_load), .int_fs(int_fs), .conv_data(conv_data),
    .pin_adv(pin_adv), .pin_ret(pin_ret), .dout(dout), .phase_adv(phase_adv),
    .phase_ret(phase_ret), .sec_req(sec_req), .rx_data(rx_data),
    .rx_valid(rx_valid), .err_window(err_window)
  );

  always @(negedge clk) if (!rst) begin
    if (phase_adv) n_adv++;
    if (phase_ret) n_ret++;
    if (sec_req)   n_sec++;
    if (rx_valid)  n_val++;
  end

  // {word, adv, ret, sec} for primary words in normal mode (R3)
  localparam logic [18:0] VEC [6] = '{
    {16'h1230, 3'b000}, {16'h4561, 3'b100}, {16'h789A, 3'b010},
    {16'hBCD3, 3'b001}, {16'hFFFC, 3'b000}, {16'h0001, 3'b100}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] w, input logic ld, input int gap, output logic [15:0] rx);
    @(negedge clk); int_fs = 1'b1;
    @(negedge clk); int_fs = 1'b0;
    repeat (gap) @(negedge clk);
    n_adv = 0; n_ret = 0; n_sec = 0; n_val = 0;
    fsync = 1'b1; shift_tick = 1'b1; int_load = ld;
    @(negedge clk); fsync = 1'b0; shift_tick = 1'b0; int_load = 1'b0;
    for (int k = 15; k >= 0; k--) begin
      rx[k] = dout; din = w[k]; shift_tick = 1'b1;
      @(negedge clk); shift_tick = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_cmd(input string req, input int a, input int r, input int s);
    chk(req, "adv pulses", a, n_adv);
    chk(req, "ret pulses", r, n_ret);
    chk(req, "sec pulses", s, n_sec);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "dout", dout, 0);
    chk("R1", "pulses", {phase_adv, phase_ret, sec_req, rx_valid}, 0);
    chk("R1", "err_window", err_window, 0);

    conv_data = 16'hA55A; int_load = 1'b1;
    @(negedge clk); int_load = 1'b0;

    for (int i = 0; i < 6; i++) begin
      run_frame(VEC[i][18:3], 1'b0, 0, rx);
      expect_cmd("R3", int'(VEC[i][2]), int'(VEC[i][1]), int'(VEC[i][0]));
      chk("R2", "rx_data", rx_data, VEC[i][18:3]);
      chk("R2", "rx_valid count", n_val, 1);
      chk("R2", "dout word", rx, 16'hA55A);
      if (VEC[i][0]) begin
        run_frame(16'h0001, 1'b0, 0, rx);
        chk("R4", "secondary dout", rx, 16'h0000);
        expect_cmd("R4", 0, 0, 0);
      end
    end

    // R4: wrong address is ignored
    run_frame(16'h0003, 1'b0, 0, rx);
    run_frame(16'h0501, 1'b0, 0, rx);
    run_frame(16'h0000, 1'b0, 0, rx);
    expect_cmd("R4", 0, 0, 0);

    // R5: 16-bit mode
    run_frame(16'h0003, 1'b0, 0, rx);
    run_frame(16'h0601, 1'b0, 0, rx);
    run_frame(16'h1111, 1'b0, 0, rx);
    expect_cmd("R5", 0, 0, 1);
    run_frame(16'h0000, 1'b0, 0, rx);
    run_frame(16'h2222, 1'b0, 0, rx);
    expect_cmd("R5", 0, 0, 1);
    run_frame(16'h0600, 1'b0, 0, rx);
    run_frame(16'h2220, 1'b0, 0, rx);
    expect_cmd("R5", 0, 0, 0);

    // R6: forced secondary keeps phase commands
    run_frame(16'h0003, 1'b0, 0, rx);
    run_frame(16'h0604, 1'b0, 0, rx);
    run_frame(16'h0001, 1'b0, 0, rx);
    expect_cmd("R6", 1, 0, 1);
    run_frame(16'h0000, 1'b0, 0, rx);
    run_frame(16'h0002, 1'b0, 0, rx);
    expect_cmd("R6", 0, 1, 1);
    run_frame(16'h0600, 1'b0, 0, rx);
    run_frame(16'h0000, 1'b0, 0, rx);
    expect_cmd("R6", 0, 0, 0);

    // R7: hardware pins and frame-sync timing
    pin_adv = 1'b1;
    run_frame(16'h0000, 1'b0, 0, rx);
    pin_adv = 1'b0;
    expect_cmd("R7", 1, 0, 0);
    pin_ret = 1'b1;
    run_frame(16'h0000, 1'b0, 0, rx);
    pin_ret = 1'b0;
    expect_cmd("R7", 0, 1, 0);
    run_frame(16'h0000, 1'b0, 30, rx);
    expect_cmd("R7", 0, 0, 0);

    // R8: normal-mode load coinciding with frame start
    conv_data = 16'h1357;
    run_frame(16'h0000, 1'b1, 0, rx);
    chk("R8", "coincident load sent", rx, 16'h1357);
    run_frame(16'h0000, 1'b0, 0, rx);
    chk("R8", "latched value", rx, 16'h1357);

    // R9: free-run collision
    run_frame(16'h0003, 1'b0, 0, rx);
    run_frame(16'h0602, 1'b0, 0, rx);
    conv_data = 16'h2468;
    run_frame(16'h0000, 1'b1, 0, rx);
    chk("R9", "old data kept", rx, 16'h1357);
    chk("R10", "in-window no error", err_window, 0);
    run_frame(16'h0000, 1'b0, 0, rx);
    chk("R9", "deferred data sent", rx, 16'h2468);

    // R10: window violation and stickiness
    run_frame(16'h0000, 1'b0, 30, rx);
    chk("R10", "error set", err_window, 1);
    expect_cmd("R7", 0, 0, 0);
    run_frame(16'h0000, 1'b0, 0, rx);
    chk("R10", "error sticky", err_window, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule